// File: doc/BRIEF.md
# GPIO Port Interrupt Unit

This block watches the eight input lines of one GPIO port and raises interrupts from them. Each line has its own settings. One bit picks level or edge sensing, one picks the active sense, one enables the line onto the interrupt outputs, and one places a debounce filter in its path. Software reaches the block through a byte-wide register interface with a 5-bit byte offset. Writes take effect on the clock edge. Reads are combinational on the offset. A latched edge is cleared by writing a one to its bit in the acknowledge register. Level-sensitive lines need no clearing, because their status follows the qualified input directly.

Each pin passes through a two-flop synchronizer. It then goes through a per-line debounce stage, built as a two-state machine. In `FLT_STABLE` the accepted value is held, and any difference from it moves the line to `FLT_SETTLE` with the run counter at one. In `FLT_SETTLE` there are three outcomes:
- An input equal to the held value returns the line to `FLT_STABLE`, so the glitch is rejected.
- A difference that has lasted `DB_CYCLES` consecutive samples is accepted and returns the line to `FLT_STABLE`.
- Otherwise the counter advances.

Clearing the line's filter bit forces `FLT_STABLE` and passes the synchronized value through with one register of delay. The edge detector compares the filtered value with its copy from one cycle earlier. It uses the sense bit as it stands in that cycle, so software can flip the sense after each edge and catch both edges. Interrupts come out in two forms: one masked request per line, and their OR.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the type, sense, enable and filter registers read 0, and both interrupt outputs are low. With the pins held low, raw status reads 0xFF, because every line then defaults to level-low.
- R2: The registers sit at these byte offsets:
  - 0x00: type (1 = edge)
  - 0x04: sense (1 = high level or rising edge)
  - 0x08: acknowledge (write-only, reads 0)
  - 0x0C: enable
  - 0x10: masked status (read-only)
  - 0x14: raw status (read-only)
  - 0x18: filter
  
  Type, sense, enable and filter read back what was written. Writes to 0x10, 0x14 and any other offset change nothing.
- R3: A line with type bit 0 shows raw status 1 exactly while its qualified input equals its sense bit.
- R4: A line with type bit 1 latches raw status 1 on a rising edge when its sense bit is 1, and on a falling edge when its sense bit is 0. An edge in the other direction does not set the status, and a latched status holds until it is acknowledged.
- R5: Writing 1 to an acknowledge bit clears that line's latched edge status on the next edge. Writing 0 to a bit leaves that line's status as it was.
- R6: Acknowledge writes have no effect on level-sensitive lines.
- R7: An edge detected in the same cycle as an acknowledge of that line leaves the status set.
- R8: Edge detection uses the sense bit current in the cycle of the edge. Flipping the sense after an edge makes the next, opposite edge latch.
- R9: Masked status equals raw status AND enable. `irq_line_o` equals masked status, and `irq_any_o` is the OR of its bits.
- R10: With the filter bypassed, an edge whose new pin value is first sampled at clock edge e0 shows in raw status after edge e3, and not before.
- R11: With the filter bit set, a new input value is accepted only after it has been seen for `DB_CYCLES` consecutive clock samples. With the default of 4, a 3-cycle pulse is dropped and a 4-cycle pulse is taken. With the bit clear, a 2-cycle pulse is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | LINES | Asynchronous GPIO pin levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | LINES | Write data |
| rdata_o | output | LINES | Read data for `addr_i` |
| irq_line_o | output | LINES | Per-line masked interrupt requests |
| irq_any_o | output | 1 | OR of all per-line requests |

## Verification
On every cycle, the assertions check the rules of the edge latch:
- A detected edge on an edge line sets its bit.
- An acknowledge with no coinciding edge clears the bit.
- An edge that coincides with an acknowledge wins.
- A latched bit holds while it is not acknowledged.

They also check that per-line requests never appear on disabled lines, that the acknowledge offset reads zero, and that a filtered line only changes after its synchronized input has agreed for the preceding samples.

Only the bench scenarios can show these:
- The exact three-edge latency.
- The 3-versus-4-cycle debounce boundary.
- The level sweeps across sense patterns.
- Catching both edges by flipping the sense.
- That acknowledges leave level lines untouched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_ADDR_W = 5;

    localparam logic [REG_ADDR_W-1:0] OFS_TYPE  = 5'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_SENSE = 5'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_ACK   = 5'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_ENA   = 5'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_PEND  = 5'h10;
    localparam logic [REG_ADDR_W-1:0] OFS_RAW   = 5'h14;
    localparam logic [REG_ADDR_W-1:0] OFS_FILT  = 5'h18;

    typedef enum logic {
        FLT_STABLE = 1'b0,
        FLT_SETTLE = 1'b1
    } flt_state_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W         = 8,
    parameter int unsigned DB_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] dout_o
);

    localparam int unsigned CNT_W = $clog2(DB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    for (genvar gi = 0; gi < W; gi++) begin : g_line
        flt_state_t       state_q, state_n;
        logic [CNT_W-1:0] run_q, run_n;
        logic             held_q, held_n;

        // state register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= FLT_STABLE;
                run_q   <= '0;
                held_q  <= 1'b0;
            end else begin
                state_q <= state_n;
                run_q   <= run_n;
                held_q  <= held_n;
            end
        end

        // next state and accepted value
        always_comb begin
            state_n = state_q;
            run_n   = run_q;
            held_n  = held_q;
            if (!en_i[gi]) begin
                state_n = FLT_STABLE;
                run_n   = '0;
                held_n  = din_i[gi];
            end else begin
                unique case (state_q)
                    FLT_STABLE: begin
                        if (din_i[gi] != held_q) begin
                            state_n = FLT_SETTLE;
                            run_n   = CNT_ONE;
                        end
                    end
                    FLT_SETTLE: begin
                        if (din_i[gi] == held_q) begin
                            state_n = FLT_STABLE;
                            run_n   = '0;
                        end else if (run_q == CNT_LAST) begin
                            state_n = FLT_STABLE;
                            run_n   = '0;
                            held_n  = din_i[gi];
                        end else begin
                            run_n = run_q + CNT_ONE;
                        end
                    end
                endcase
            end
        end

        assign dout_o[gi] = held_q;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] qual_i,
    input  logic [W-1:0] sense_i,
    output logic [W-1:0] hit_o,
    output logic [W-1:0] lvl_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= qual_i;
        end
    end

    always_comb begin
        hit_o = (sense_i & qual_i & ~prev_q) | (~sense_i & ~qual_i & prev_q);
        lvl_o = ~(qual_i ^ sense_i);
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [W-1:0]          wdata_i,
    input  logic [W-1:0]          raw_i,
    output logic [W-1:0]          type_o,
    output logic [W-1:0]          sense_o,
    output logic [W-1:0]          ena_o,
    output logic [W-1:0]          filt_o,
    output logic [W-1:0]          ack_o,
    output logic [W-1:0]          rdata_o
);

    logic [W-1:0] type_q, sense_q, ena_q, filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q  <= '0;
            sense_q <= '0;
            ena_q   <= '0;
            filt_q  <= '0;
        end else if (wr_en_i) begin
            case (addr_i)
                OFS_TYPE:  type_q  <= wdata_i;
                OFS_SENSE: sense_q <= wdata_i;
                OFS_ENA:   ena_q   <= wdata_i;
                OFS_FILT:  filt_q  <= wdata_i;
                default:   ;
            endcase
        end
    end

    always_comb begin
        ack_o = (wr_en_i && addr_i == OFS_ACK) ? wdata_i : '0;
        case (addr_i)
            OFS_TYPE:  rdata_o = type_q;
            OFS_SENSE: rdata_o = sense_q;
            OFS_ENA:   rdata_o = ena_q;
            OFS_PEND:  rdata_o = raw_i & ena_q;
            OFS_RAW:   rdata_o = raw_i;
            OFS_FILT:  rdata_o = filt_q;
            default:   rdata_o = '0;
        endcase
    end

    assign type_o  = type_q;
    assign sense_o = sense_q;
    assign ena_o   = ena_q;
    assign filt_o  = filt_q;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES     = 8,
    parameter int unsigned DB_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LINES-1:0]      pin_i,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [LINES-1:0]      wdata_i,
    output logic [LINES-1:0]      rdata_o,
    output logic [LINES-1:0]      irq_line_o,
    output logic                  irq_any_o
);

    logic [LINES-1:0] sync_v, flt_v, hit_v, lvl_v;
    logic [LINES-1:0] mode_q, pol_q, ena_q, filt_q, ack_v;
    logic [LINES-1:0] st_q, raw_v;

    gpio_irq_sync #(.W(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (sync_v)
    );

    gpio_irq_filter #(.W(LINES), .DB_CYCLES(DB_CYCLES)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (sync_v),
        .en_i   (filt_q),
        .dout_o (flt_v)
    );

    gpio_irq_detect #(.W(LINES)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual_i  (flt_v),
        .sense_i (pol_q),
        .hit_o   (hit_v),
        .lvl_o   (lvl_v)
    );

    gpio_irq_regs #(.W(LINES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .raw_i   (raw_v),
        .type_o  (mode_q),
        .sense_o (pol_q),
        .ena_o   (ena_q),
        .filt_o  (filt_q),
        .ack_o   (ack_v),
        .rdata_o (rdata_o)
    );

    // edge latch: a new edge outranks a same-cycle acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= mode_q & ((st_q & ~ack_v) | hit_v);
        end
    end

    always_comb begin
        raw_v      = (mode_q & st_q) | (~mode_q & lvl_v);
        irq_line_o = raw_v & ena_q;
        irq_any_o  = |irq_line_o;
    end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] addr_i,
    input logic [LINES-1:0]      rdata_o,
    input logic [LINES-1:0]      irq_line_o,
    input logic [LINES-1:0]      ena_q,
    input logic [LINES-1:0]      mode_q,
    input logic [LINES-1:0]      ack_v,
    input logic [LINES-1:0]      hit_v,
    input logic [LINES-1:0]      st_q,
    input logic [LINES-1:0]      sync_v,
    input logic [LINES-1:0]      flt_v,
    input logic [LINES-1:0]      filt_q
);

    p_ack_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == OFS_ACK) |-> (rdata_o == '0));

    p_edge_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_v & mode_q) != '0) |=>
        ((st_q & $past(hit_v & mode_q)) == $past(hit_v & mode_q)));

    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & mode_q & ~ack_v) != '0) |=>
        ((st_q & $past(st_q & mode_q & ~ack_v)) == $past(st_q & mode_q & ~ack_v)));

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_v & ~hit_v) != '0) |=>
        ((st_q & $past(ack_v & ~hit_v)) == '0));

    p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_v & hit_v & mode_q) != '0) |=>
        ((st_q & $past(ack_v & hit_v & mode_q)) == $past(ack_v & hit_v & mode_q)));

    p_pend_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_line_o & ~ena_q) == '0));

    for (genvar gi = 0; gi < LINES; gi++) begin : g_flt
        p_filter_settle_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ((flt_v[gi] != $past(flt_v[gi])) && $past(filt_q[gi]) && $past(filt_q[gi], 2)) |->
            (($past(sync_v[gi]) == flt_v[gi]) && ($past(sync_v[gi], 2) == flt_v[gi])));
    end

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.LINES(LINES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .irq_line_o (irq_line_o),
    .ena_q      (ena_q),
    .mode_q     (mode_q),
    .ack_v      (ack_v),
    .hit_v      (hit_v),
    .st_q       (st_q),
    .sync_v     (sync_v),
    .flt_v      (flt_v),
    .filt_q     (filt_q)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;

    localparam logic [4:0] A_TYPE = 5'h00, A_SENSE = 5'h04, A_ACK = 5'h08,
                           A_ENA = 5'h0C, A_PEND = 5'h10, A_RAW = 5'h14,
                           A_FILT = 5'h18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'h00;
    logic       wr_en = 1'b0;
    logic [4:0] addr = 5'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, irq_line;
    logic       irq_any;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pins),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_line_o (irq_line),
        .irq_any_o  (irq_any)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pins = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] ena;
        logic [7:0] sp;
        logic [7:0] m;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(5);

        // R1 reset state
        rd(A_TYPE, v);  chk("R1 type reset", v, 8'h00);
        rd(A_SENSE, v); chk("R1 sense reset", v, 8'h00);
        rd(A_ENA, v);   chk("R1 enable reset", v, 8'h00);
        rd(A_FILT, v);  chk("R1 filter reset", v, 8'h00);
        rd(A_PEND, v);  chk("R1 masked reset", v, 8'h00);
        rd(A_RAW, v);   chk("R1 raw level-low default", v, 8'hFF);
        chk("R1 irq_line reset", irq_line, 8'h00);
        chk("R1 irq_any reset", {7'd0, irq_any}, 8'h00);

        // R2 register map
        wr(A_TYPE, 8'h5A); wr(A_SENSE, 8'hC3); wr(A_ENA, 8'h96); wr(A_FILT, 8'h0F);
        wr(A_RAW, 8'hFF); wr(A_PEND, 8'hFF); wr(5'h1C, 8'hFF); wr(5'h01, 8'hFF);
        rd(A_TYPE, v);  chk("R2 type readback", v, 8'h5A);
        rd(A_SENSE, v); chk("R2 sense readback", v, 8'hC3);
        rd(A_ENA, v);   chk("R2 enable readback", v, 8'h96);
        rd(A_FILT, v);  chk("R2 filter readback", v, 8'h0F);
        rd(A_ACK, v);   chk("R2 ack reads zero", v, 8'h00);

        // R3 / R9 level sweep
        wr(A_TYPE, 8'h00); wr(A_FILT, 8'h00);
        ena = 8'hA5;
        wr(A_ENA, ena);
        for (int s = 0; s < 3; s++) begin
            sp = (s == 0) ? 8'h00 : (s == 1) ? 8'hFF : 8'h3C;
            wr(A_SENSE, sp);
            for (int p = 0; p < 256; p += 17) begin
                set_pins(8'(p));
                settle(4);
                rd(A_RAW, v);  chk("R3 level raw", v, ~(8'(p) ^ sp));
                rd(A_PEND, v); chk("R9 masked status", v, ~(8'(p) ^ sp) & ena);
                chk("R9 irq_line", irq_line, ~(8'(p) ^ sp) & ena);
                chk("R9 irq_any", {7'd0, irq_any}, {7'd0, |(~(8'(p) ^ sp) & ena)});
            end
        end

        // R6 acknowledge ignored by level lines
        wr(A_SENSE, 8'hFF); set_pins(8'h0F); settle(4);
        wr(A_ACK, 8'hFF);
        rd(A_RAW, v); chk("R6 level unaffected by ack", v, 8'h0F);

        // R4 / R5 per-line edge sweep
        wr(A_TYPE, 8'hFF); wr(A_ENA, 8'hFF);
        for (int i = 0; i < 8; i++) begin
            for (int b = 0; b < 2; b++) begin
                m = 8'(1 << i);
                sp = b ? 8'hFF : 8'h00;
                wr(A_SENSE, sp);
                set_pins(~sp); settle(5);
                wr(A_ACK, 8'hFF);
                rd(A_RAW, v); chk("R4 idle after ack", v, 8'h00);
                set_pins(~sp ^ m); settle(5);
                rd(A_RAW, v); chk("R4 active edge latched", v, m);
                wr(A_ACK, m);
                rd(A_RAW, v); chk("R5 ack clears", v, 8'h00);
                set_pins(~sp); settle(5);
                rd(A_RAW, v); chk("R4 opposite edge ignored", v, 8'h00);
                set_pins(~sp ^ m); settle(5);
                wr(A_ACK, ~m);
                rd(A_RAW, v); chk("R5 zero bits keep status", v, m);
                wr(A_ACK, m);
                rd(A_RAW, v); chk("R5 ack clears again", v, 8'h00);
            end
        end

        // R8 both edges by flipping sense
        wr(A_SENSE, 8'hFF); set_pins(8'h00); settle(5); wr(A_ACK, 8'hFF);
        set_pins(8'h01); settle(5);
        rd(A_RAW, v); chk("R8 rising latched", v, 8'h01);
        wr(A_SENSE, 8'hFE); wr(A_ACK, 8'h01);
        rd(A_RAW, v); chk("R8 cleared before fall", v, 8'h00);
        set_pins(8'h00); settle(5);
        rd(A_RAW, v); chk("R8 falling latched after flip", v, 8'h01);

        // R10 latency
        wr(A_SENSE, 8'hFF); wr(A_ACK, 8'hFF);
        @(negedge clk); addr = A_RAW; pins = 8'h01;
        @(negedge clk); @(negedge clk); @(negedge clk);
        #1 chk("R10 not before third edge", rdata, 8'h00);
        @(negedge clk);
        #1 chk("R10 visible after third edge", rdata, 8'h01);

        // R7 edge and ack in the same cycle
        set_pins(8'h00); settle(5); wr(A_ACK, 8'hFF);
        @(negedge clk); pins = 8'h01;
        @(negedge clk); @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = A_ACK; wdata = 8'h01;
        @(negedge clk); wr_en = 1'b0;
        rd(A_RAW, v); chk("R7 edge wins over ack", v, 8'h01);
        set_pins(8'h00); settle(5); wr(A_ACK, 8'hFF);
        @(negedge clk); pins = 8'h01;
        @(negedge clk); @(negedge clk); @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = A_ACK; wdata = 8'h01;
        @(negedge clk); wr_en = 1'b0;
        rd(A_RAW, v); chk("R5 ack one cycle later clears", v, 8'h00);

        // R11 debounce boundary
        set_pins(8'h00); wr(A_FILT, 8'hFF); settle(10); wr(A_ACK, 8'hFF);
        @(negedge clk); pins = 8'h01;
        repeat (3) @(negedge clk);
        pins = 8'h00; settle(10);
        rd(A_RAW, v); chk("R11 3-cycle pulse dropped", v, 8'h00);
        @(negedge clk); pins = 8'h01;
        repeat (4) @(negedge clk);
        pins = 8'h00; settle(10);
        rd(A_RAW, v); chk("R11 4-cycle pulse taken", v, 8'h01);
        wr(A_FILT, 8'h00); settle(5); wr(A_ACK, 8'hFF);
        @(negedge clk); pins = 8'h01;
        repeat (2) @(negedge clk);
        pins = 8'h00; settle(8);
        rd(A_RAW, v); chk("R11 bypass takes 2-cycle pulse", v, 8'h01);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule